// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This block holds the 8-bit status word of a small 8-bit processor and works out its next value each cycle. Several sources can write it. The ALU supplies flag candidates from an 8-bit or 16-bit result. A command port carries explicit set and clear requests. A memory-bit test copies two bits of a data byte. A full-load port restores the whole word when a status byte is popped from the stack or an interrupt returns.

Each flag has its own update rules, and some of them are lopsided. Overflow and half carry can be cleared by a command but can never be set by one. Negative ignores every command. The interrupt enable changes only through its two commands and the full load. The stored word drives branch-condition outputs and the direct-page select.

Every flag sits at a fixed bit position. From bit 7 down to bit 0 the order is N, V, G, B, H, I, Z, C. When several sources write the same flag in one cycle, one winner is chosen in this order:

1. full load
2. command
3. bit test
4. ALU
5. hold the current value

Top module: `stat_word_core`

## Requirements
- R1: While reset is asserted the status word reads 00h. It still reads 00h at the first clock edge after reset is released.
- R2: The ALU result is captured when `alu_en` and `alu_arith` are both high, with the layout N=7, V=6, G=5, B=4, H=3, I=2, Z=1, C=0. At that edge C takes `alu_cy7` (carry out of bit 7, or no-borrow for subtraction). H takes `alu_cy3`, V takes `alu_ovf`, N takes bit 7 of the result and Z is set when the low byte is zero.
- R3: When `alu_en` is high and `alu_arith` is low (a data transfer), only N and Z change. C, H and V keep their values.
- R4: When `alu_wide` is high, Z is set only if all 16 result bits are zero, and N takes result bit 15.
- R5: `flag_cmd` code 1 sets C and code 2 clears C. This wins over an ALU carry in the same cycle.
- R6: Code 3 sets I and code 4 clears I. Apart from the full load, nothing else changes I.
- R7: Code 5 sets G and code 6 clears G. `dp_page1` equals G.
- R8: Code 7 clears both V and H. No command ever sets V or H, and no command changes N.
- R9: Code 8 (software break) sets B and leaves the other flags alone. Codes 0 and 9 to 15 change nothing.
- R10: When `btst_en` is high, N takes `btst_data[7]` and V takes `btst_data[6]`. This wins over the ALU; code 7 still wins over the bit test for V.
- R11: When `load_en` is high, the word becomes `load_data` at the next edge, whatever the other inputs request.
- R12: `br_cs`/`br_cc` show C set or clear, `br_eq`/`br_ne` show Z set or clear, and `br_vs`/`br_vc` show V set or clear, all taken from the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_en | input | 1 | An ALU or transfer result is present |
| alu_arith | input | 1 | Result is arithmetic, so C, H and V are updated as well |
| alu_wide | input | 1 | Result is 16 bits wide |
| alu_result | input | 16 | Result value (low byte used when narrow) |
| alu_cy7 | input | 1 | Carry out of bit 7, or no-borrow |
| alu_cy3 | input | 1 | Carry out of bit 3, or no-borrow from bit 4 |
| alu_ovf | input | 1 | Signed overflow or underflow |
| flag_cmd | input | 4 | Flag command code |
| btst_en | input | 1 | Memory-bit test strobe |
| btst_data | input | 8 | Memory byte under test |
| load_en | input | 1 | Full-word load strobe |
| load_data | input | 8 | Word to load |
| psw | output | 8 | Stored status word |
| dp_page1 | output | 1 | Direct page 1 selected |
| br_cs | output | 1 | Carry set |
| br_cc | output | 1 | Carry clear |
| br_eq | output | 1 | Zero set |
| br_ne | output | 1 | Zero clear |
| br_vs | output | 1 | Overflow set |
| br_vc | output | 1 | Overflow clear |

## Verification
Every write source lands in the register at the rising edge that samples it, so the new word appears one cycle after the stimulus. The branch outputs and `dp_page1` follow in the same cycle, because they are decoded from the stored word without further delay. The bench changes inputs on the falling edge and waits through exactly one rising edge. It then compares all outputs on the next falling edge against a reference word that it advances with the same single-cycle step. Directed cases come first to pit sources against each other in one cycle, followed by a long random mix that keeps the reference word in step.

// File: rtl/stat_word_pkg.sv
package stat_word_pkg;
   // Bit positions: other logic decodes these, so the order is fixed
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_I = 2;
   localparam int FL_H = 3;
   localparam int FL_B = 4;
   localparam int FL_G = 5;
   localparam int FL_V = 6;
   localparam int FL_N = 7;
   localparam int FLAG_CNT = 8;

   typedef enum logic [3:0] {
      FCMD_NOP     = 4'd0,
      FCMD_SET_C   = 4'd1,
      FCMD_CLR_C   = 4'd2,
      FCMD_INT_ON  = 4'd3,
      FCMD_INT_OFF = 4'd4,
      FCMD_SET_G   = 4'd5,
      FCMD_CLR_G   = 4'd6,
      FCMD_CLR_V   = 4'd7,
      FCMD_BRK     = 4'd8
   } fcmd_e;
endpackage

// File: rtl/stat_word_cmd_dec.sv
module stat_word_cmd_dec
   import stat_word_pkg::*;
#(
   parameter int FLAGS = FLAG_CNT
) (
   input  logic [3:0]       cmd,
   output logic [FLAGS-1:0] set_m,
   output logic [FLAGS-1:0] clr_m
);
   always_comb begin
      set_m = '0;
      clr_m = '0;
      case (fcmd_e'(cmd))
         FCMD_SET_C:   set_m[FL_C] = 1'b1;
         FCMD_CLR_C:   clr_m[FL_C] = 1'b1;
         FCMD_INT_ON:  set_m[FL_I] = 1'b1;
         FCMD_INT_OFF: clr_m[FL_I] = 1'b1;
         FCMD_SET_G:   set_m[FL_G] = 1'b1;
         FCMD_CLR_G:   clr_m[FL_G] = 1'b1;
         FCMD_CLR_V: begin
            clr_m[FL_V] = 1'b1;
            clr_m[FL_H] = 1'b1;
         end
         FCMD_BRK:     set_m[FL_B] = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/stat_word_alu_src.sv
module stat_word_alu_src
   import stat_word_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int WIDE_W = 2 * DATA_W
) (
   input  logic              en,
   input  logic              arith,
   input  logic              wide,
   input  logic [WIDE_W-1:0] res,
   input  logic              cy7,
   input  logic              cy3,
   input  logic              ovf,
   input  logic              bt_en,
   input  logic [DATA_W-1:0] bt_data,
   output logic [FLAG_CNT-1:0] we,
   output logic [FLAG_CNT-1:0] val
);
   logic lo_zero;
   logic hi_zero;

   assign lo_zero = (res[DATA_W-1:0] == '0);
   assign hi_zero = (res[WIDE_W-1:DATA_W] == '0);

   always_comb begin
      we  = '0;
      val = '0;
      if (en) begin
         we[FL_N]  = 1'b1;
         we[FL_Z]  = 1'b1;
         val[FL_N] = wide ? res[WIDE_W-1] : res[DATA_W-1];
         val[FL_Z] = lo_zero & (hi_zero | ~wide);
         if (arith) begin
            we[FL_C]  = 1'b1;
            we[FL_H]  = 1'b1;
            we[FL_V]  = 1'b1;
            val[FL_C] = cy7;
            val[FL_H] = cy3;
            val[FL_V] = ovf;
         end
      end
      // bit test outranks the ALU for N and V
      if (bt_en) begin
         we[FL_N]  = 1'b1;
         we[FL_V]  = 1'b1;
         val[FL_N] = bt_data[DATA_W-1];
         val[FL_V] = bt_data[DATA_W-2];
      end
   end
endmodule

// File: rtl/stat_word_merge.sv
module stat_word_merge
   import stat_word_pkg::*;
#(
   parameter int FLAGS = FLAG_CNT
) (
   input  logic [FLAGS-1:0] cur,
   input  logic             ld_en,
   input  logic [FLAGS-1:0] ld_val,
   input  logic [FLAGS-1:0] set_m,
   input  logic [FLAGS-1:0] clr_m,
   input  logic [FLAGS-1:0] src_we,
   input  logic [FLAGS-1:0] src_val,
   output logic [FLAGS-1:0] nxt
);
   for (genvar b = 0; b < FLAGS; b++) begin : g_bit
      always_comb begin
         if (ld_en)           nxt[b] = ld_val[b];
         else if (set_m[b])   nxt[b] = 1'b1;
         else if (clr_m[b])   nxt[b] = 1'b0;
         else if (src_we[b])  nxt[b] = src_val[b];
         else                 nxt[b] = cur[b];
      end
   end
endmodule

// File: rtl/stat_word_cond.sv
module stat_word_cond
   import stat_word_pkg::*;
(
   input  logic [FLAG_CNT-1:0] q,
   output logic                page1,
   output logic                cs,
   output logic                cc,
   output logic                eq,
   output logic                ne,
   output logic                vs,
   output logic                vc
);
   assign page1 = q[FL_G];
   assign cs    = q[FL_C];
   assign cc    = ~q[FL_C];
   assign eq    = q[FL_Z];
   assign ne    = ~q[FL_Z];
   assign vs    = q[FL_V];
   assign vc    = ~q[FL_V];
endmodule

// File: rtl/stat_word_core.sv
module stat_word_core
   import stat_word_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int WIDE_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alu_en,
   input  logic              alu_arith,
   input  logic              alu_wide,
   input  logic [WIDE_W-1:0] alu_result,
   input  logic              alu_cy7,
   input  logic              alu_cy3,
   input  logic              alu_ovf,
   input  logic [3:0]        flag_cmd,
   input  logic              btst_en,
   input  logic [DATA_W-1:0] btst_data,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] psw,
   output logic              dp_page1,
   output logic              br_cs,
   output logic              br_cc,
   output logic              br_eq,
   output logic              br_ne,
   output logic              br_vs,
   output logic              br_vc
);
   if (DATA_W != FLAG_CNT) begin : g_width_check
      $error("stat_word_core: DATA_W must equal the flag count");
   end

   logic [FLAG_CNT-1:0] q_r;
   logic [FLAG_CNT-1:0] nxt;
   logic [FLAG_CNT-1:0] set_m;
   logic [FLAG_CNT-1:0] clr_m;
   logic [FLAG_CNT-1:0] src_we;
   logic [FLAG_CNT-1:0] src_val;

   stat_word_cmd_dec #(.FLAGS(FLAG_CNT)) u_dec (
      .cmd   (flag_cmd),
      .set_m (set_m),
      .clr_m (clr_m)
   );

   stat_word_alu_src #(.DATA_W(DATA_W)) u_src (
      .en      (alu_en),
      .arith   (alu_arith),
      .wide    (alu_wide),
      .res     (alu_result),
      .cy7     (alu_cy7),
      .cy3     (alu_cy3),
      .ovf     (alu_ovf),
      .bt_en   (btst_en),
      .bt_data (btst_data),
      .we      (src_we),
      .val     (src_val)
   );

   stat_word_merge #(.FLAGS(FLAG_CNT)) u_merge (
      .cur     (q_r),
      .ld_en   (load_en),
      .ld_val  (load_data),
      .set_m   (set_m),
      .clr_m   (clr_m),
      .src_we  (src_we),
      .src_val (src_val),
      .nxt     (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= nxt;
   end

   assign psw = q_r;

   stat_word_cond u_cond (
      .q     (q_r),
      .page1 (dp_page1),
      .cs    (br_cs),
      .cc    (br_cc),
      .eq    (br_eq),
      .ne    (br_ne),
      .vs    (br_vs),
      .vc    (br_vc)
   );
endmodule

// File: rtl/stat_word_chk.sv
module stat_word_chk
   import stat_word_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       alu_en,
   input logic       alu_arith,
   input logic [3:0] flag_cmd,
   input logic       btst_en,
   input logic [7:0] btst_data,
   input logic       load_en,
   input logic [7:0] load_data,
   input logic [7:0] psw,
   input logic       br_cs,
   input logic       br_eq,
   input logic       br_ne,
   input logic       br_vc
);
   // R1
   reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> psw == 8'h00);

   // R11
   full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> psw == $past(load_data));

   // R6
   int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && flag_cmd != FCMD_INT_ON && flag_cmd != FCMD_INT_OFF)
      |=> $stable(psw[FL_I]));

   // R8
   v_no_cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !btst_en && !(alu_en && alu_arith)) |=> !$rose(psw[FL_V]));

   // R10
   bit_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (btst_en && !load_en && flag_cmd != FCMD_CLR_V)
      |=> psw[FL_N:FL_V] == $past(btst_data[7:6]));

   // R12
   branch_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_cs == psw[FL_C] && br_eq != br_ne && br_eq == psw[FL_Z] && br_vc != psw[FL_V]);
endmodule

bind stat_word_core stat_word_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .alu_en    (alu_en),
   .alu_arith (alu_arith),
   .flag_cmd  (flag_cmd),
   .btst_en   (btst_en),
   .btst_data (btst_data),
   .load_en   (load_en),
   .load_data (load_data),
   .psw       (psw),
   .br_cs     (br_cs),
   .br_eq     (br_eq),
   .br_ne     (br_ne),
   .br_vc     (br_vc)
);

// File: tb/stat_word_core_tb.sv
module stat_word_core_tb;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alu_en = 0, alu_arith = 0, alu_wide = 0;
   logic [15:0] alu_result = '0;
   logic        alu_cy7 = 0, alu_cy3 = 0, alu_ovf = 0;
   logic [3:0]  flag_cmd = '0;
   logic        btst_en = 0;
   logic [7:0]  btst_data = '0;
   logic        load_en = 0;
   logic [7:0]  load_data = '0;
   logic [7:0]  psw;
   logic        dp_page1, br_cs, br_cc, br_eq, br_ne, br_vs, br_vc;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [7:0] exp_q = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   stat_word_core u_dut (
      .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .alu_arith(alu_arith),
      .alu_wide(alu_wide), .alu_result(alu_result), .alu_cy7(alu_cy7),
      .alu_cy3(alu_cy3), .alu_ovf(alu_ovf), .flag_cmd(flag_cmd),
      .btst_en(btst_en), .btst_data(btst_data), .load_en(load_en),
      .load_data(load_data), .psw(psw), .dp_page1(dp_page1),
      .br_cs(br_cs), .br_cc(br_cc), .br_eq(br_eq), .br_ne(br_ne),
      .br_vs(br_vs), .br_vc(br_vc)
   );

   // reference: later writes have higher priority
   function automatic logic [7:0] model(input logic [7:0] q);
      logic [7:0] n = q;
      if (alu_en) begin
         n[7] = alu_wide ? alu_result[15] : alu_result[7];
         n[1] = alu_wide ? (alu_result == 16'h0) : (alu_result[7:0] == 8'h0);
         if (alu_arith) begin
            n[0] = alu_cy7; n[3] = alu_cy3; n[6] = alu_ovf;
         end
      end
      if (btst_en) begin
         n[7] = btst_data[7]; n[6] = btst_data[6];
      end
      case (flag_cmd)
         4'd1: n[0] = 1'b1;
         4'd2: n[0] = 1'b0;
         4'd3: n[2] = 1'b1;
         4'd4: n[2] = 1'b0;
         4'd5: n[5] = 1'b1;
         4'd6: n[5] = 1'b0;
         4'd7: begin n[6] = 1'b0; n[3] = 1'b0; end
         4'd8: n[4] = 1'b1;
         default: ;
      endcase
      if (load_en) n = load_data;
      return n;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      alu_en = 0; alu_arith = 0; alu_wide = 0; alu_result = '0;
      alu_cy7 = 0; alu_cy3 = 0; alu_ovf = 0; flag_cmd = '0;
      btst_en = 0; btst_data = '0; load_en = 0; load_data = '0;
   endtask

   // inputs already set while clk is low; one edge, then compare at the falling edge
   task automatic step(input string tag);
      exp_q = model(exp_q);
      @(posedge clk);
      @(negedge clk);
      check(tag, {24'h0, psw}, {24'h0, exp_q});
      check("R12", {26'h0, br_cs, br_cc, br_eq, br_ne, br_vs, br_vc},
            {26'h0, exp_q[0], ~exp_q[0], exp_q[1], ~exp_q[1], exp_q[6], ~exp_q[6]});
      check("R7", {31'h0, dp_page1}, {31'h0, exp_q[5]});
      idle();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      idle();
      repeat (3) @(negedge clk);
      check("R1", {24'h0, psw}, 32'h0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R1", {24'h0, psw}, 32'h0);

      // R2 arithmetic result
      alu_en = 1; alu_arith = 1; alu_result = 16'h0080; alu_cy7 = 1; alu_cy3 = 1; alu_ovf = 1;
      step("R2");
      // R3 transfer keeps C/H/V
      alu_en = 1; alu_result = 16'h0000; alu_cy7 = 0; alu_cy3 = 0; alu_ovf = 0;
      step("R3");
      // R4 low byte zero but high byte set: Z clear, N from bit 15
      alu_en = 1; alu_wide = 1; alu_result = 16'h8000;
      step("R4");
      alu_en = 1; alu_wide = 1; alu_result = 16'h0000;
      step("R4");
      // R5 command beats ALU carry
      alu_en = 1; alu_arith = 1; alu_cy7 = 0; alu_result = 16'h0011; flag_cmd = 4'd1;
      step("R5");
      flag_cmd = 4'd2; alu_en = 1; alu_arith = 1; alu_cy7 = 1;
      step("R5");
      // R6
      flag_cmd = 4'd3; step("R6");
      alu_en = 1; alu_arith = 1; alu_result = 16'h00FF; btst_en = 1; btst_data = 8'hFF; step("R6");
      flag_cmd = 4'd4; step("R6");
      // R7
      flag_cmd = 4'd5; step("R7");
      flag_cmd = 4'd6; step("R7");
      // R8: V and H set, then clear by command; command beats bit test
      alu_en = 1; alu_arith = 1; alu_cy3 = 1; alu_ovf = 1; step("R8");
      flag_cmd = 4'd7; btst_en = 1; btst_data = 8'hC0; step("R8");
      // R9
      flag_cmd = 4'd8; step("R9");
      flag_cmd = 4'd12; step("R9");
      // R10 bit test over ALU
      alu_en = 1; alu_arith = 1; alu_result = 16'h0080; alu_ovf = 1;
      btst_en = 1; btst_data = 8'h3F; step("R10");
      btst_en = 1; btst_data = 8'h40; step("R10");
      // R11 load beats everything
      load_en = 1; load_data = 8'h5A; flag_cmd = 4'd1; btst_en = 1; btst_data = 8'hFF;
      alu_en = 1; alu_arith = 1; alu_cy7 = 0;
      step("R11");
      load_en = 1; load_data = 8'hA5; flag_cmd = 4'd8; step("R11");

      // random mix
      for (int k = 0; k < 4000; k++) begin
         string tag;
         alu_en     = ($urandom_range(1, 0) == 1);
         alu_arith  = ($urandom_range(1, 0) == 1);
         alu_wide   = ($urandom_range(3, 0) == 0);
         alu_result = ($urandom_range(3, 0) == 0) ? 16'h0000 : 16'($urandom);
         alu_cy7    = $urandom_range(1, 0) == 1;
         alu_cy3    = $urandom_range(1, 0) == 1;
         alu_ovf    = $urandom_range(1, 0) == 1;
         flag_cmd   = ($urandom_range(1, 0) == 1) ? 4'($urandom_range(15, 0)) : 4'd0;
         btst_en    = ($urandom_range(7, 0) == 0);
         btst_data  = 8'($urandom);
         load_en    = ($urandom_range(15, 0) == 0);
         load_data  = 8'($urandom);
         if (load_en) tag = "R11";
         else if (flag_cmd >= 4'd3 && flag_cmd <= 4'd4) tag = "R6";
         else if (flag_cmd == 4'd7) tag = "R8";
         else if (btst_en) tag = "R10";
         else if (alu_en && alu_wide) tag = "R4";
         else if (alu_en && alu_arith) tag = "R2";
         else if (alu_en) tag = "R3";
         else tag = "R9";
         step(tag);
      end

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule